// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Driver

This block runs the convert-and-read cycle of a simultaneous-sampling converter that holds two 14-bit successive-approximation ADCs and has two serial result lines. It starts each conversion with an active-low convert strobe and waits a fixed, parameterised conversion time. It then frames the readout with an active-low chip select and produces the serial clock by dividing the system clock. Both results are gathered into one 32-bit word, which is announced by a one-cycle ready pulse. Conversions repeat back to back while reset is released.

Two readout arrangements are supported. In two-line mode each ADC delivers its result on its own line, and both results are read at the same time. In one-line mode the two results come out one after the other on the channel A line. The busy signal from the converter is accepted but plays no part: completion is judged purely by elapsed cycles. The block needs no processor and can be dropped into any design that has a system clock.

Top module: `dual_adc_capture`

## Requirements
- R1: While reset (rstN low) is held, cnvstN, csN and sclk are high, dataReady is low and dataOut is zero.
- R2: Each conversion holds cnvstN low for exactly CNV_LOW_CYC system cycles (default 4), and csN stays high throughout that time.
- R3: csN falls exactly CONV_WAIT_CYC system cycles (default 60) after cnvstN returns high.
- R4: sclk is high whenever csN is high. Within a frame it falls together with csN and then has a period of SCLK_DIV cycles (default 4), low for the first half. A frame has 14 falling edges in two-line mode and 28 in one-line mode, so sclk is low for SCLK_DIV/2 cycles per bit.
- R5: Each bit is captured on the system edge at which sclk rises, which is after the converter has shifted it out on the preceding falling edge. Bits arrive MSB first.
- R6: Two-line mode (lineMode = 0): the channel A result is read from doutA and the channel B result from doutB, 14 bits each, in parallel.
- R7: One-line mode (lineMode = 1): 28 bits are read from doutA, the channel A result first and the channel B result second. doutB is ignored.
- R8: dataOut carries channel A in bits 29:16 and channel B in bits 13:0. Bits 31:30 and 15:14 are zero.
- R9: dataReady is high for exactly one cycle per converted pair. dataOut changes only in the cycle in which dataReady is high.
- R10: The busy input has no effect on any output.
- R11: lineMode is sampled on the edge at which cnvstN falls. A change later in the frame does not affect that frame.
- R12: The next conversion begins in the same cycle in which dataReady is high (cnvstN is low then).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineMode | input | 1 | 1 = one-line readout, 0 = two-line readout |
| doutA | input | 1 | Serial result line of ADC A |
| doutB | input | 1 | Serial result line of ADC B |
| busy | input | 1 | Converter busy flag, not used |
| dataOut | output | 32 | Packed result: channel A upper half, channel B lower half |
| dataReady | output | 1 | One-cycle pulse marking a new dataOut |
| sclk | output | 1 | Serial clock to the converter |
| cnvstN | output | 1 | Convert-start strobe, active low |
| csN | output | 1 | Chip select framing the readout, active low |

## Verification
The hardest case to reach from the ports is a change of lineMode after the conversion has started. The design must use the mode it latched on the falling convert strobe. A change that is caught a cycle late, or a shift path that follows the live input, produces the wrong word only in that frame. The bench therefore waits for cnvstN to fall, flips lineMode one cycle later, and still expects the word packed for the original mode. On the converter side, a model shifts the bits out on every falling sclk edge and drives toggling garbage on doutB in one-line mode. Frames are also run with busy toggling every cycle, so that any reliance on doutB or on busy shows up as a mismatch.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT,
    ST_READ,
    ST_DONE
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleEn;  // capture one bit on each active line
    logic loadOut;   // pack shift registers into the output word
    logic oneLine;   // latched readout mode for the current frame
  } capStrobe_t;

endpackage

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int SCLK_DIV      = 4,
  parameter int CNV_LOW_CYC   = 4,
  parameter int CONV_WAIT_CYC = 60,
  parameter int RES_BITS      = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineMode,
  output logic       cnvstN,
  output logic       csN,
  output logic       sclk,
  output capStrobe_t strobe
);

  localparam int HALF    = SCLK_DIV / 2;
  localparam int CYC_MAX = (CNV_LOW_CYC > CONV_WAIT_CYC) ? CNV_LOW_CYC : CONV_WAIT_CYC;
  localparam int CYC_W   = $clog2(CYC_MAX + 1);
  localparam int DIV_W   = $clog2(SCLK_DIV);
  localparam int BIT_W   = $clog2(2 * RES_BITS);

  localparam logic [CYC_W-1:0] CNV_LAST  = CYC_W'(CNV_LOW_CYC - 1);
  localparam logic [CYC_W-1:0] WAIT_LAST = CYC_W'(CONV_WAIT_CYC - 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(SCLK_DIV - 1);
  localparam logic [DIV_W-1:0] HALF_V    = DIV_W'(HALF);
  localparam logic [DIV_W-1:0] SAMP_AT   = DIV_W'(HALF - 1);
  localparam logic [BIT_W-1:0] LAST_ONE  = BIT_W'(2 * RES_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_TWO  = BIT_W'(RES_BITS - 1);

  capState_t        state;
  logic [CYC_W-1:0] cycCnt;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             modeQ;
  logic             sampleHit;
  logic [BIT_W-1:0] lastBit;

  assign sampleHit = (state == ST_READ) && (divCnt == SAMP_AT);
  assign lastBit   = modeQ ? LAST_ONE : LAST_TWO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
      divCnt <= '0;
      bitCnt <= '0;
      modeQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          state  <= ST_CNV;
          modeQ  <= lineMode;
          cycCnt <= '0;
        end
        ST_CNV: begin
          if (cycCnt == CNV_LAST) begin
            state  <= ST_WAIT;
            cycCnt <= '0;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cycCnt == WAIT_LAST) begin
            state  <= ST_READ;
            divCnt <= '0;
            bitCnt <= '0;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_READ: begin
          divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
          if (sampleHit) begin
            if (bitCnt == lastBit) state <= ST_DONE;
            else                   bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cnvstN = (state != ST_CNV);
  assign csN    = (state != ST_READ);
  assign sclk   = !((state == ST_READ) && (divCnt < HALF_V));

  assign strobe.sampleEn = sampleHit;
  assign strobe.loadOut  = (state == ST_DONE);
  assign strobe.oneLine  = modeQ;

endmodule

// File: rtl/adc_cap_dpath.sv
module adc_cap_dpath
  import adc_cap_pkg::*;
#(
  parameter int RES_BITS = 14,
  parameter int HALF_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  capStrobe_t            strobe,
  input  logic                  doutA,
  input  logic                  doutB,
  output logic [2*HALF_W-1:0]   dataOut,
  output logic                  dataReady
);

  localparam int PAIR = 2 * RES_BITS;

  logic [PAIR-1:0]     shiftA;
  logic [RES_BITS-1:0] shiftB;
  logic [RES_BITS-1:0] resA, resB;
  logic [HALF_W-1:0]   extA, extB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftA <= '0;
      shiftB <= '0;
    end else if (strobe.sampleEn) begin
      shiftA <= {shiftA[PAIR-2:0], doutA};
      shiftB <= {shiftB[RES_BITS-2:0], doutB};
    end
  end

  always_comb begin
    if (strobe.oneLine) begin
      resA = shiftA[PAIR-1:RES_BITS];
      resB = shiftA[RES_BITS-1:0];
    end else begin
      resA = shiftA[RES_BITS-1:0];
      resB = shiftB;
    end
    extA = HALF_W'(resA);
    extB = HALF_W'(resB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataReady <= 1'b0;
    end else begin
      dataReady <= strobe.loadOut;
      if (strobe.loadOut) dataOut <= {extA, extB};
    end
  end

endmodule

// File: rtl/dual_adc_capture.sv
module dual_adc_capture
  import adc_cap_pkg::*;
#(
  parameter int SCLK_DIV      = 4,
  parameter int CNV_LOW_CYC   = 4,
  parameter int CONV_WAIT_CYC = 60,
  parameter int RES_BITS      = 14,
  parameter int HALF_W        = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineMode,
  input  logic                doutA,
  input  logic                doutB,
  input  logic                busy,
  output logic [2*HALF_W-1:0] dataOut,
  output logic                dataReady,
  output logic                sclk,
  output logic                cnvstN,
  output logic                csN
);

  capStrobe_t strobe;
  logic       unusedBusy;

  // completion is timed, the busy flag is deliberately not consumed
  assign unusedBusy = busy;

  adc_cap_ctrl #(
    .SCLK_DIV(SCLK_DIV), .CNV_LOW_CYC(CNV_LOW_CYC),
    .CONV_WAIT_CYC(CONV_WAIT_CYC), .RES_BITS(RES_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lineMode(lineMode),
    .cnvstN(cnvstN), .csN(csN), .sclk(sclk), .strobe(strobe)
  );

  adc_cap_dpath #(.RES_BITS(RES_BITS), .HALF_W(HALF_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .doutA(doutA), .doutB(doutB),
    .dataOut(dataOut), .dataReady(dataReady)
  );

endmodule

// File: rtl/dual_adc_capture_chk.sv
module dual_adc_capture_chk #(
  parameter int CNV_LOW_CYC   = 4,
  parameter int CONV_WAIT_CYC = 60,
  parameter int RES_BITS      = 14,
  parameter int HALF_W        = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                cnvstN,
  input logic                csN,
  input logic                sclk,
  input logic [2*HALF_W-1:0] dataOut,
  input logic                dataReady
);

  localparam int LW = $clog2(CNV_LOW_CYC + 2);
  localparam int WW = $clog2(CONV_WAIT_CYC + 2);
  localparam logic [LW-1:0] LOW_EXP  = LW'(CNV_LOW_CYC);
  localparam logic [WW-1:0] WAIT_EXP = WW'(CONV_WAIT_CYC);
  localparam logic [WW-1:0] WAIT_SAT = '1;

  logic [LW-1:0] lowCnt;
  logic [WW-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      waitCnt <= '0;
    end else begin
      lowCnt  <= cnvstN ? '0 : lowCnt + 1'b1;
      waitCnt <= !cnvstN ? '0 : ((waitCnt == WAIT_SAT) ? waitCnt : waitCnt + 1'b1);
    end
  end

  AST_CNV_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cnvstN) |-> lowCnt == LOW_EXP);  // R2
  AST_CS_QUIET_CNV: assert property (@(posedge clk) disable iff (!rstN)
    !cnvstN |-> csN);  // R2
  AST_CS_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> waitCnt == WAIT_EXP);  // R3
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);  // R4
  AST_SCLK_FIRST_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk);  // R4
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> ((dataOut[HALF_W +: HALF_W] >> RES_BITS) == '0) &&
                  ((dataOut[0 +: HALF_W] >> RES_BITS) == '0));  // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |=> !dataReady);  // R9
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !dataReady |-> $stable(dataOut));  // R9
  AST_NEXT_CNV: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> !cnvstN);  // R12

endmodule

bind dual_adc_capture dual_adc_capture_chk #(
  .CNV_LOW_CYC(CNV_LOW_CYC), .CONV_WAIT_CYC(CONV_WAIT_CYC),
  .RES_BITS(RES_BITS), .HALF_W(HALF_W)
) uChk (
  .clk(clk), .rstN(rstN), .cnvstN(cnvstN), .csN(csN), .sclk(sclk),
  .dataOut(dataOut), .dataReady(dataReady)
);

// File: tb/sim_dual_adc_capture.sv
`timescale 1ns/1ps
module sim_dual_adc_capture;

  localparam int DIV  = 4;
  localparam int CNVL = 4;
  localparam int WAIT = 60;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineMode = 1'b0;
  logic        doutA = 1'b0;
  logic        doutB = 1'b0;
  logic        busy = 1'b0;
  logic [31:0] dataOut;
  logic        dataReady, sclk, cnvstN, csN;

  dual_adc_capture #(.SCLK_DIV(DIV), .CNV_LOW_CYC(CNVL), .CONV_WAIT_CYC(WAIT)) u0 (
    .clk(clk), .rstN(rstN), .lineMode(lineMode), .doutA(doutA), .doutB(doutB),
    .busy(busy), .dataOut(dataOut), .dataReady(dataReady), .sclk(sclk),
    .cnvstN(cnvstN), .csN(csN)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  // converter model
  logic [13:0] curA = '0, curB = '0;
  bit          frameOne = 0;
  bit          busyNoise = 0;
  int          bitIdx = 0;
  int          sclkFalls = 0;
  int          sclkLowCyc = 0;

  always @(negedge cnvstN) begin
    bitIdx = 0;
    sclkFalls = 0;
    sclkLowCyc = 0;
  end

  always @(negedge sclk) begin
    logic [27:0] pairWord;
    pairWord = {curA, curB};
    if (frameOne) begin
      if (bitIdx < 28) doutA = pairWord[27 - bitIdx];
      doutB = ~doutB;  // garbage on the unused line
    end else if (bitIdx < 14) begin
      doutA = curA[13 - bitIdx];
      doutB = curB[13 - bitIdx];
    end
    bitIdx++;
    sclkFalls++;
  end

  always @(posedge clk) if (busyNoise) busy <= ~busy;

  // scoreboard
  logic [31:0] expQ[$];
  string       reqQ[$];

  task automatic runFrame(input logic [13:0] a, input logic [13:0] b, input bit one,
                          input bit flipMid, input bit noisy);
    int expFalls;
    lineMode  = one;
    curA      = a;
    curB      = b;
    frameOne  = one;
    busyNoise = noisy;
    expFalls  = one ? 28 : 14;
    @(negedge cnvstN);
    expQ.push_back({2'b00, a, 2'b00, b});
    if (flipMid)    reqQ.push_back("R11");
    else if (noisy) reqQ.push_back("R10");
    else if (one)   reqQ.push_back("R7/R8");
    else            reqQ.push_back("R6/R8");
    if (flipMid) begin
      @(negedge clk);
      lineMode = ~one;
    end
    @(posedge csN);
    #1;
    check(sclkFalls == expFalls, "R4 sclk falls per frame", sclkFalls, expFalls);
    check(sclkLowCyc == expFalls * (DIV / 2), "R5 sclk low cycles", sclkLowCyc, expFalls * (DIV / 2));
    busyNoise = 0;
  endtask

  // monitor
  int          lowCnt = 0;
  int          waitCnt = 0;
  bit          inWait = 0;
  bit          prevReady = 0;
  bit          holdViol = 0;
  logic [31:0] lastOut = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!csN && !sclk) sclkLowCyc++;
      if (!cnvstN) begin
        lowCnt++;
        if (!csN) check(0, "R2 csN high during convert strobe", {31'b0, csN}, 32'd1);
      end else begin
        if (lowCnt != 0) begin
          check(lowCnt == CNVL, "R2 convert strobe width", lowCnt, CNVL);
          lowCnt = 0;
          inWait = 1;
          waitCnt = 0;
        end
        if (inWait) begin
          if (csN) waitCnt++;
          else begin
            check(waitCnt == WAIT, "R3 conversion wait", waitCnt, WAIT);
            inWait = 0;
          end
        end
      end
      if (!dataReady && dataOut != lastOut) holdViol = 1;
      if (dataReady) begin
        logic [31:0] e;
        string r;
        check(!prevReady, "R9 ready single cycle", {31'b0, prevReady}, 32'd0);
        check(!cnvstN, "R12 next conversion with ready", {31'b0, cnvstN}, 32'd0);
        check(sclk && csN, "R4 sclk idle high", {30'b0, sclk, csN}, 32'd3);
        if (expQ.size() == 0) begin
          check(0, "R9 unexpected ready", dataOut, 32'd0);
        end else begin
          e = expQ.pop_front();
          r = reqQ.pop_front();
          check(dataOut == e, r, dataOut, e);
        end
      end
      prevReady = dataReady;
      lastOut   = dataOut;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(cnvstN && csN && sclk, "R1 strobes high in reset", {29'b0, cnvstN, csN, sclk}, 32'd7);
    check(!dataReady, "R1 ready low in reset", {31'b0, dataReady}, 32'd0);
    check(dataOut == '0, "R1 output zero in reset", dataOut, 32'd0);
    lineMode = 1'b0;
    curA = 14'h2A5C;
    curB = 14'h1357;
    rstN = 1'b1;
    runFrame(14'h2A5C, 14'h1357, 0, 0, 0);  // R6
    runFrame(14'h3FFF, 14'h0000, 1, 0, 0);  // R7
    runFrame(14'h0000, 14'h3FFF, 0, 0, 0);  // R6
    runFrame(14'h1555, 14'h2AAA, 1, 0, 0);  // R7
    runFrame(14'h0ABC, 14'h3123, 0, 0, 1);  // R10
    runFrame(14'h2468, 14'h1ACE, 1, 0, 1);  // R10
    runFrame(14'h3001, 14'h0C30, 1, 1, 0);  // R11
    runFrame(14'h0F0F, 14'h30F0, 0, 1, 0);  // R11
    runFrame(14'h3FFF, 14'h3FFF, 0, 0, 0);  // R8
    runFrame(14'h0001, 14'h2000, 1, 0, 0);  // R5
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R9 all pairs delivered", expQ.size(), 32'd0);
    check(!holdViol, "R9 output held between pulses", {31'b0, holdViol}, 32'd0);
    finishRun();
  end

endmodule